// File: doc/BRIEF.md
# Sigma-Delta Temperature Back-End

This block turns the one-bit output of a first-order charge-balancing temperature modulator into a signed reading in degrees Celsius. A start pulse opens a conversion. The block then takes bitstream samples whenever the valid strobe is high. It weights them with a triangular (second-order sinc) window, which yields the average bit density mu of the conversion.

The modulator runs at a small gain. The block therefore remaps the density to a curvature-compensated PTAT ratio with the fixed transform 9·mu/(1+8·mu). A sequential restoring divider performs this remap. A programmable gain and offset turn the ratio into Celsius. A programmable square-law term then removes residual systematic nonlinearity, and the result is clamped to the operating range.

The reading appears on a 1/64 °C output together with a one-cycle done flag. The output keeps that reading until the next conversion completes.

Top module: `tsense_backend`

## Requirements
- R1: After reset, busy and done are 0 and temp_out is 0.
- R2: A start pulse clears the accumulation and begins a conversion. busy is high from the following edge until done. A start that arrives while busy discards the work in progress, so only the restarted conversion reports. A bit presented in the same cycle as start is not counted.
- R3: A conversion takes exactly 2·HALF_LEN accepted bits (6000 by default). Accepted bit k (0-based) has weight k+1 for k < HALF_LEN and 2·HALF_LEN−1−k otherwise. The weighted sum acc therefore lies between 0 and HALF_LEN².
- R4: The PTAT ratio is q = floor(9·acc·2^24 / (HALF_LEN² + 8·acc)). This is an unsigned value with 24 fractional bits, which equals 9·mu/(1+8·mu) with mu = acc/HALF_LEN². An all-ones stream gives exactly q = 2^24.
- R5: The gain coef_a and offset coef_b are unsigned with 10 fractional bits, and coef_c2 is signed in 1/64 °C units. With d = q − 2^23, the block forms s = coef_a·q − coef_b·2^24 + 16·coef_c2·floor(d²/2^24). The unclamped reading is floor(s/2^28), in two's complement with 1/64 °C steps.
- R6: The reading saturates to the range −5120 to +8640 (−80 °C to +135 °C).
- R7: done is a one-cycle pulse, and busy is low while done is high. done and the new temp_out appear on the 26th rising edge after the edge that samples the final bit. temp_out does not change between done pulses.
- R8: Valid bits that arrive while idle, or after the final bit while the division runs, have no effect on any result.
- R9: bit_in is ignored in cycles where bit_valid is low, and such gap cycles do not advance the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start or restart a conversion |
| bit_valid | input | 1 | bit_in carries a modulator sample this cycle |
| bit_in | input | 1 | Modulator bitstream sample |
| coef_a | input | 20 | Gain, unsigned, 10 fractional bits |
| coef_b | input | 20 | Offset, unsigned, 10 fractional bits |
| coef_c2 | input | 16 | Square-law correction, signed, 1/64 °C units |
| busy | output | 1 | Conversion or division in progress |
| done | output | 1 | One-cycle pulse when temp_out updates |
| temp_out | output | 16 | Signed temperature, 1/64 °C |

## Verification
The hardest situation to reach from the ports is a conversion whose weighted density lands on a chosen ratio. Exact quotient floors and nonzero square-law corrections need such a density. The bench produces it with a first-order error-feedback bit generator fed with a target fraction, and it mixes in gap cycles that carry junk on bit_in. A second hard case is a restart that lands partway through a stream: a start is issued after a thousand ones, and the bench expects exactly one report. The saturation limits and the exact-unity quotient come from constant all-zero and all-ones streams.

// File: rtl/tsense_backend.sv
module tsense_backend #(
  parameter int HALF_LEN  = 3000,
  parameter int FRAC_W    = 24,
  parameter int COEF_W    = 20,
  parameter int COEF_FRAC = 10,
  parameter int C2_W      = 16,
  parameter int OUT_W     = 16,
  parameter int OUT_FRAC  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    bit_valid,
  input  logic                    bit_in,
  input  logic [COEF_W-1:0]       coef_a,
  input  logic [COEF_W-1:0]       coef_b,
  input  logic signed [C2_W-1:0]  coef_c2,
  output logic                    busy,
  output logic                    done,
  output logic signed [OUT_W-1:0] temp_out
);
  localparam int CONV_LEN = 2 * HALF_LEN;
  localparam int CNT_W    = $clog2(CONV_LEN + 1);
  localparam int ACC_W    = $clog2(HALF_LEN * HALF_LEN + 1);
  localparam int NUM_W    = ACC_W + 4;
  localparam int Q_W      = FRAC_W + 1;
  localparam int IT_W     = $clog2(FRAC_W + 1);
  localparam int SUM_W    = COEF_W + Q_W + 4;
  localparam int OUT_SH   = COEF_FRAC + FRAC_W - OUT_FRAC;
  localparam int C2_SH    = COEF_FRAC - OUT_FRAC;
  localparam int TQ_W     = SUM_W - OUT_SH;
  localparam int T_MIN    = -80 * (2 ** OUT_FRAC);
  localparam int T_MAX    = 135 * (2 ** OUT_FRAC);
  localparam logic signed [TQ_W-1:0]  TQ_MIN  = TQ_W'(T_MIN);
  localparam logic signed [TQ_W-1:0]  TQ_MAX  = TQ_W'(T_MAX);
  localparam logic signed [OUT_W-1:0] OUT_MIN = OUT_W'(T_MIN);
  localparam logic signed [OUT_W-1:0] OUT_MAX = OUT_W'(T_MAX);
  localparam logic [NUM_W-1:0] WSUM = NUM_W'(HALF_LEN * HALF_LEN);

  typedef enum logic [2:0] {S_IDLE, S_ACC, S_LOAD, S_DIV, S_FIN} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [ACC_W-1:0] acc;
  logic [NUM_W-1:0] rem, den_r;
  logic [Q_W-1:0]   quo;
  logic [IT_W-1:0]  it;

  // triangular window: rising half then falling half
  logic [CNT_W-1:0] wt;
  assign wt = (cnt < CNT_W'(HALF_LEN)) ? cnt + 1'b1 : CNT_W'(CONV_LEN - 1) - cnt;

  logic [NUM_W-1:0] acc8, num9, den_c;
  assign acc8  = {1'b0, acc, 3'b000};
  assign num9  = acc8 + {4'b0000, acc};
  assign den_c = WSUM + acc8;

  logic [NUM_W:0] rem_sh;
  assign rem_sh = {rem, 1'b0};

  // Celsius mapping and square-law correction
  logic [SUM_W-1:0]         prod_a, b_term;
  logic signed [Q_W:0]      dev;
  logic signed [2*Q_W+1:0]  dsq;
  logic [Q_W-1:0]           dsq_q;
  logic signed [C2_W+Q_W:0] corr;
  logic signed [SUM_W-1:0]  sum;
  logic signed [TQ_W-1:0]   tq;
  logic signed [OUT_W-1:0]  t_sat;

  assign prod_a = SUM_W'(coef_a) * SUM_W'(quo);
  assign b_term = SUM_W'(coef_b) << FRAC_W;
  assign dev    = $signed({1'b0, quo}) - $signed((Q_W + 1)'(1) << (FRAC_W - 1));
  assign dsq    = dev * dev;
  assign dsq_q  = dsq[FRAC_W +: Q_W];
  assign corr   = coef_c2 * $signed({1'b0, dsq_q});
  assign sum    = $signed(prod_a) - $signed(b_term) + ($signed(SUM_W'(corr)) <<< C2_SH);
  assign tq     = sum[SUM_W-1:OUT_SH];
  assign t_sat  = (tq < TQ_MIN) ? OUT_MIN : (tq > TQ_MAX) ? OUT_MAX : OUT_W'(tq);

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      acc      <= '0;
      rem      <= '0;
      den_r    <= '0;
      quo      <= '0;
      it       <= '0;
      done     <= 1'b0;
      temp_out <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state <= S_ACC;
        cnt   <= '0;
        acc   <= '0;
      end else begin
        case (state)
          S_ACC: if (bit_valid) begin
            if (bit_in) acc <= acc + {{(ACC_W-CNT_W){1'b0}}, wt};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(CONV_LEN - 1)) state <= S_LOAD;
          end
          S_LOAD: begin
            den_r <= den_c;
            it    <= '0;
            if (num9 >= den_c) begin
              quo <= Q_W'(1);
              rem <= num9 - den_c;
            end else begin
              quo <= '0;
              rem <= num9;
            end
            state <= S_DIV;
          end
          S_DIV: begin
            if (rem_sh >= {1'b0, den_r}) begin
              rem <= NUM_W'(rem_sh - {1'b0, den_r});
              quo <= {quo[Q_W-2:0], 1'b1};
            end else begin
              rem <= rem_sh[NUM_W-1:0];
              quo <= {quo[Q_W-2:0], 1'b0};
            end
            it <= it + 1'b1;
            if (it == IT_W'(FRAC_W - 1)) state <= S_FIN;
          end
          S_FIN: begin
            temp_out <= t_sat;
            done     <= 1'b1;
            state    <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(temp_out));
  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> (busy && cnt == '0 && acc == '0));
  // R6
  range_chk: assert property (@(posedge clk) disable iff (!rst_n) (temp_out >= OUT_MIN) && (temp_out <= OUT_MAX));
  // R4
  quo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) (state == S_FIN) |-> (quo <= Q_W'(1) << FRAC_W));
  // R8
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n) (state == S_IDLE && !start) |=> ($stable(acc) && $stable(cnt)));
  // R3
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) acc <= ACC_W'(HALF_LEN * HALF_LEN));
endmodule

// File: tb/tb_tsense_backend.sv
module tb_tsense_backend;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3000;
  localparam int LAT = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic [19:0] coef_a = '0, coef_b = '0;
  logic signed [15:0] coef_c2 = '0;
  logic busy, done;
  logic signed [15:0] temp_out;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tsense_backend dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid), .bit_in(bit_in),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c2(coef_c2),
    .busy(busy), .done(done), .temp_out(temp_out)
  );

  task automatic check_eq(input longint act, input longint exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic int expected_temp(longint acc, longint a, longint b, longint c2);
    longint q, d, dsq, s, t;
    q   = ((9 * acc) <<< 24) / (longint'(N) * N + 8 * acc);
    d   = q - (longint'(1) <<< 23);
    dsq = (d * d) >>> 24;
    s   = a * q - (b <<< 24) + ((c2 * dsq) <<< 4);
    t   = s >>> 28;
    if (t < -5120) t = -5120;
    if (t > 8640) t = 8640;
    return int'(t);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R2: actual unexpected result %0d expected no report", temp_out);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check_eq(temp_out, e, t);
      end
    end
  end

  task automatic run_conv(input longint a, input longint b, input longint c2,
                          input int num, input int den, input int gap_every,
                          input bit junk_tail, input string tag);
    longint acc = 0;
    int phase = 0;
    int k = 0;
    int cyc = 0;
    int n = 0;
    coef_a = 20'(a);
    coef_b = 20'(b);
    coef_c2 = 16'(c2);
    @(posedge clk); #1;
    start = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check_eq(busy, 1, "R2 busy after start");
    while (k < 2 * N) begin
      if (gap_every != 0 && (cyc % gap_every) == 0) begin
        bit_valid = 1'b0;
        bit_in = 1'b1;
      end else begin
        bit_valid = 1'b1;
        phase += num;
        if (phase >= den) begin
          bit_in = 1'b1;
          phase -= den;
          acc += (k < N) ? k + 1 : 2 * N - 1 - k;
        end else begin
          bit_in = 1'b0;
        end
        k++;
      end
      cyc++;
      @(posedge clk); #1;
    end
    bit_valid = junk_tail;
    bit_in = junk_tail;
    exp_q.push_back(expected_temp(acc, a, b, c2));
    tag_q.push_back(tag);
    while (n < 100) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done) break;
    end
    check_eq(n, LAT, "R7 latency");
    bit_valid = 1'b0;
    bit_in = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq(busy, 0, "R1 busy");
    check_eq(done, 0, "R1 done");
    check_eq(temp_out, 0, "R1 temp_out");
    #1 rst_n = 1'b1;

    // R6 low clamp: zero density, offset drives far below range
    run_conv(614400, 279706, 0, 0, 1, 0, 1'b0, "R6 low clamp");
    // R4 unity quotient with R5 mapping: all ones
    run_conv(307200, 279706, 0, 1, 1, 0, 1'b0, "R4 unity ratio");
    // R6 high clamp
    run_conv(614400, 279706, 0, 1, 1, 0, 1'b0, "R6 high clamp");
    // R3 R5 mid density
    run_conv(614400, 279706, 0, 9, 50, 0, 1'b1, "R5 mid density");
    // R5 positive correction, R9 gaps with junk
    run_conv(614400, 279706, 640, 9, 50, 7, 1'b0, "R9 gaps and R5 c2");
    // R5 negative correction, low density
    run_conv(600000, 270000, -1000, 1, 10, 0, 1'b1, "R5 negative c2");

    // R8 idle junk must not move temp_out nor raise done
    held = temp_out;
    @(posedge clk); #1;
    bit_valid = 1'b1; bit_in = 1'b1;
    repeat (40) @(posedge clk);
    #1 bit_valid = 1'b0;
    @(negedge clk);
    check_eq(temp_out, held, "R8 idle bits");
    check_eq(busy, 0, "R8 idle busy");

    // R2 restart partway
    @(posedge clk); #1;
    start = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (1000) @(posedge clk);
    #1;
    run_conv(614400, 279706, 200, 3, 20, 0, 1'b0, "R2 restart result");

    repeat (40) @(posedge clk);
    @(negedge clk);
    check_eq(exp_q.size(), 0, "R2 all results reported");
    summary();
  end
endmodule